// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out aligned, power-of-two sized pieces of one address region and takes them back. The region (1024 units by default) is split into blocks whose sizes run from a minimum (64 units by default) up to the whole region. Each size is an "order": order k is a block of `MIN_UNITS << k` units, so the default gives five orders, 0 to 4. The block keeps track of which aligned blocks are free with one bitmap per order.

An allocation request gives a size in units. The block rounds it up to the smallest order that covers it. It then takes the lowest-addressed free block from the smallest order that has one. If that order is larger than needed, the block halves it one step per cycle. It keeps the lower half each time and marks the upper half free. The result is the base unit address and the order, or a fail flag.

A release gives a base address and an order. The block checks the block's buddy, which sits at base XOR size. If the buddy is free, the two merge into one block one order up, one merge per cycle. This goes on until the buddy is in use or the whole region is one free block. Only one operation runs at a time.

Top module: `buddy_allocator`

## Requirements
- R1: After reset, the whole region is one free block of the highest order and no smaller block is free. `busy`, `alloc_done` and `free_done` are low.
- R2: A request of size s is granted the smallest order k for which `MIN_UNITS << k >= s`. A size of 0 up to `MIN_UNITS` gets order 0.
- R3: `alloc_base` is a unit address, and it is a multiple of the granted block size `MIN_UNITS << alloc_order`.
- R4: Among the orders at or above the needed one, the smallest order that holds a free block is used. Within that order, the free block with the lowest address is taken.
- R5: When the chosen block is larger than needed, it is halved once per cycle. The lower half is kept, and each upper half becomes a free block of its order.
- R6: A size larger than the region gives `alloc_fail` with `alloc_done`, and the free state is left as it was.
- R7: A request that no free block can serve gives `alloc_fail` with `alloc_done`, and the free state is left as it was.
- R8: A released block merges with its buddy (base XOR size) whenever that buddy is free. Merging repeats one order at a time, up to a free block covering the whole region.
- R9: Merging stops at the first order whose buddy is not free, and the block built so far stays free at that order.
- R10: `alloc_done` and `free_done` are one-cycle pulses and are never high together. `busy` is high from the cycle after a request is accepted until the done pulse. Requests are ignored while `busy` is high. When both requests are raised in the same idle cycle, the allocation is taken and the release is ignored.
- R11: Counted from the accepting clock edge, an allocation's done pulse follows after 2 + (number of halvings) edges. A release's done pulse follows after 2 + (number of merges) edges. A failed allocation takes 2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Allocation request, sampled while idle |
| alloc_size | input | AW+1 (11) | Requested size in units |
| free_req | input | 1 | Release request, sampled while idle |
| free_base | input | AW (10) | Base unit address of the block being released |
| free_order | input | OW (3) | Order of the block being released |
| alloc_done | output | 1 | One-cycle pulse that ends an allocation |
| alloc_fail | output | 1 | Valid with `alloc_done`: no block was granted |
| alloc_base | output | AW (10) | Base unit address of the granted block |
| alloc_order | output | OW (3) | Order of the granted block |
| free_done | output | 1 | One-cycle pulse that ends a release |
| busy | output | 1 | An operation is in progress |

## Verification
The hardest state to reach from the ports is a partial merge. Some but not all of a chain of buddies must be free, so that a release climbs a few orders and then stops at a buddy that is still held. The bench gets there by filling the region with blocks of mixed orders and then releasing them in a chosen order. Each release's latency and the addresses of later grants show how far the merge went. Requests raised while busy, or together with another request, are checked by showing that the later grants and merges come out exactly as if the ignored request had never been raised.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIND  = 2'd1,
      ST_SPLIT = 2'd2,
      ST_MERGE = 2'd3
   } buddy_state_e;

   // bit position of order k's first block in a flat map whose top order is top_ord
   function automatic int order_offset(input int top_ord, input int k);
      return (1 << (top_ord + 1)) - (1 << (top_ord + 1 - k));
   endfunction

endpackage

// File: rtl/buddy_order_calc.sv
module buddy_order_calc #(
   parameter int ORDERS  = 5,
   parameter int MIN_LOG = 6,
   parameter int SW      = 11,
   parameter int OW      = 3
) (
   input  logic [SW-1:0] size_i,
   output logic [OW-1:0] need_order_o,
   output logic          too_big_o
);
   logic [SW-1:0] limit;

   always_comb begin
      too_big_o    = 1'b1;
      need_order_o = '0;
      limit        = '0;
      for (int k = ORDERS - 1; k >= 0; k--) begin
         limit = '0;
         limit[MIN_LOG + k] = 1'b1;
         if (size_i <= limit) begin
            need_order_o = OW'(k);
            too_big_o    = 1'b0;
         end
      end
   end
endmodule

// File: rtl/buddy_free_map.sv
module buddy_free_map #(
   parameter int ORDERS = 5,
   parameter int OW     = 3,
   parameter int IW     = 4,
   parameter int NBITS  = 31
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          set_en,
   input  logic [OW-1:0]                 set_order,
   input  logic [IW-1:0]                 set_idx,
   input  logic                          clr_en,
   input  logic [OW-1:0]                 clr_order,
   input  logic [IW-1:0]                 clr_idx,
   input  logic [OW-1:0]                 q_order,
   input  logic [IW-1:0]                 q_idx,
   output logic                          q_free,
   output logic [ORDERS-1:0]             any_free,
   output logic [ORDERS-1:0][IW-1:0]     low_idx,
   output logic [NBITS-1:0]              bits_o
);
   localparam int TOP = ORDERS - 1;
   localparam int PW  = $clog2(NBITS);

   logic [NBITS-1:0] bits;
   logic [PW-1:0]    set_pos, clr_pos, q_pos;

   always_comb begin
      set_pos = PW'(buddy_pkg::order_offset(TOP, int'(set_order)) + int'(set_idx));
      clr_pos = PW'(buddy_pkg::order_offset(TOP, int'(clr_order)) + int'(clr_idx));
      q_pos   = PW'(buddy_pkg::order_offset(TOP, int'(q_order)) + int'(q_idx));
   end

   assign q_free = bits[q_pos];
   assign bits_o = bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits <= NBITS'(1) << (NBITS - 1);
      end else begin
         if (set_en) bits[set_pos] <= 1'b1;
         if (clr_en) bits[clr_pos] <= 1'b0;
      end
   end

   for (genvar g = 0; g < ORDERS; g++) begin : g_order
      localparam int NB  = 1 << (TOP - g);
      localparam int OFF = (1 << (TOP + 1)) - (1 << (TOP + 1 - g));
      logic [NB-1:0] slice;
      assign slice       = bits[OFF +: NB];
      assign any_free[g] = |slice;
      always_comb begin
         low_idx[g] = '0;
         for (int i = NB - 1; i >= 0; i--) begin
            if (slice[i]) low_idx[g] = IW'(i);
         end
      end
   end

   assert_no_same_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && clr_en) |-> (set_pos != clr_pos));
   assert_take_only_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |-> bits[clr_pos]);
   assert_release_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |-> !bits[set_pos]);
endmodule

// File: rtl/buddy_ctrl.sv
module buddy_ctrl #(
   parameter int AW        = 10,
   parameter int MIN_LOG   = 6,
   parameter int MIN_UNITS = 64,
   parameter int ORDERS    = 5,
   parameter int OW        = 3,
   parameter int IW        = 4,
   parameter int SW        = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc_req,
   input  logic [SW-1:0]             alloc_size,
   input  logic                      free_req,
   input  logic [AW-1:0]             free_base,
   input  logic [OW-1:0]             free_order,
   input  logic [OW-1:0]             need_order,
   input  logic                      too_big,
   input  logic [ORDERS-1:0]         any_free,
   input  logic [ORDERS-1:0][IW-1:0] low_idx,
   input  logic                      q_free,
   output logic [OW-1:0]             q_order,
   output logic [IW-1:0]             q_idx,
   output logic                      set_en,
   output logic [OW-1:0]             set_order,
   output logic [IW-1:0]             set_idx,
   output logic                      clr_en,
   output logic [OW-1:0]             clr_order,
   output logic [IW-1:0]             clr_idx,
   output logic                      alloc_done,
   output logic                      alloc_fail,
   output logic [AW-1:0]             alloc_base,
   output logic [OW-1:0]             alloc_order,
   output logic                      free_done,
   output logic                      busy
);
   import buddy_pkg::*;
   localparam int TOP = ORDERS - 1;

   buddy_state_e  state;
   logic [OW-1:0] cur_order, tgt_order, pick_order;
   logic [IW-1:0] cur_idx, pick_idx, half_idx;
   logic [SW-1:0] req_size_r;
   logic          too_big_r, pick_found, can_merge;

   function automatic logic [AW-1:0] base_of(input logic [IW-1:0] idx,
                                             input logic [OW-1:0] ord);
      return AW'({idx, {MIN_LOG{1'b0}}}) << ord;
   endfunction

   assign busy      = (state != ST_IDLE);
   assign half_idx  = (cur_idx << 1) | IW'(1);
   assign can_merge = (cur_order != OW'(TOP)) && q_free;

   always_comb begin
      pick_found = 1'b0;
      pick_order = '0;
      for (int k = TOP; k >= 0; k--) begin
         if ((OW'(k) >= tgt_order) && any_free[k]) begin
            pick_found = 1'b1;
            pick_order = OW'(k);
         end
      end
      pick_idx = low_idx[pick_order];
   end

   always_comb begin
      q_order   = cur_order;
      q_idx     = cur_idx ^ IW'(1);
      set_en    = 1'b0;
      set_order = cur_order;
      set_idx   = cur_idx;
      clr_en    = 1'b0;
      clr_order = cur_order;
      clr_idx   = cur_idx;
      case (state)
         ST_FIND: begin
            if (pick_found && !too_big_r) begin
               clr_en    = 1'b1;
               clr_order = pick_order;
               clr_idx   = pick_idx;
            end
         end
         ST_SPLIT: begin
            set_en    = 1'b1;
            set_order = cur_order - 1'b1;
            set_idx   = half_idx;
         end
         ST_MERGE: begin
            if (can_merge) begin
               clr_en  = 1'b1;
               clr_idx = cur_idx ^ IW'(1);
            end else begin
               set_en = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cur_order   <= '0;
         cur_idx     <= '0;
         tgt_order   <= '0;
         too_big_r   <= 1'b0;
         req_size_r  <= '0;
         alloc_done  <= 1'b0;
         alloc_fail  <= 1'b0;
         alloc_base  <= '0;
         alloc_order <= '0;
         free_done   <= 1'b0;
      end else begin
         alloc_done <= 1'b0;
         free_done  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (alloc_req) begin
                  tgt_order  <= need_order;
                  too_big_r  <= too_big;
                  req_size_r <= alloc_size;
                  state      <= ST_FIND;
               end else if (free_req) begin
                  cur_order <= free_order;
                  cur_idx   <= IW'(free_base >> (MIN_LOG + int'(free_order)));
                  state     <= ST_MERGE;
               end
            end
            ST_FIND: begin
               if (!pick_found || too_big_r) begin
                  alloc_done <= 1'b1;
                  alloc_fail <= 1'b1;
                  state      <= ST_IDLE;
               end else if (pick_order == tgt_order) begin
                  alloc_done  <= 1'b1;
                  alloc_fail  <= 1'b0;
                  alloc_base  <= base_of(pick_idx, pick_order);
                  alloc_order <= pick_order;
                  state       <= ST_IDLE;
               end else begin
                  cur_order <= pick_order;
                  cur_idx   <= pick_idx;
                  state     <= ST_SPLIT;
               end
            end
            ST_SPLIT: begin
               cur_order <= cur_order - 1'b1;
               cur_idx   <= cur_idx << 1;
               if (cur_order - 1'b1 == tgt_order) begin
                  alloc_done  <= 1'b1;
                  alloc_fail  <= 1'b0;
                  alloc_base  <= base_of(cur_idx << 1, cur_order - 1'b1);
                  alloc_order <= cur_order - 1'b1;
                  state       <= ST_IDLE;
               end
            end
            ST_MERGE: begin
               if (can_merge) begin
                  cur_order <= cur_order + 1'b1;
                  cur_idx   <= cur_idx >> 1;
               end else begin
                  free_done <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   logic [SW-1:0] grant_size;
   assign grant_size = SW'(MIN_UNITS) << alloc_order;

   assert_grant_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_done && !alloc_fail) |->
         (grant_size >= req_size_r) && ((alloc_order == '0) || ((grant_size >> 1) < req_size_r)));
   assert_base_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_done && !alloc_fail) |-> ((alloc_base & (grant_size[AW-1:0] - 1'b1)) == '0));
   assert_split_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SPLIT) |=> (cur_order == $past(cur_order) - 1'b1));
   assert_done_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(alloc_done && free_done));
   assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_done || free_done) |-> !busy);
endmodule

// File: rtl/buddy_allocator.sv
module buddy_allocator #(
   parameter int REGION_UNITS = 1024,
   parameter int MIN_UNITS    = 64,
   localparam int AW      = $clog2(REGION_UNITS),
   localparam int MIN_LOG = $clog2(MIN_UNITS),
   localparam int ORDERS  = AW - MIN_LOG + 1,
   localparam int OW      = $clog2(ORDERS),
   localparam int SW      = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_req,
   input  logic [SW-1:0] alloc_size,
   input  logic          free_req,
   input  logic [AW-1:0] free_base,
   input  logic [OW-1:0] free_order,
   output logic          alloc_done,
   output logic          alloc_fail,
   output logic [AW-1:0] alloc_base,
   output logic [OW-1:0] alloc_order,
   output logic          free_done,
   output logic          busy
);
   localparam int TOP   = ORDERS - 1;
   localparam int IW    = TOP;
   localparam int NBITS = (1 << ORDERS) - 1;

   if (REGION_UNITS != (1 << AW)) begin : g_bad_region
      $error("REGION_UNITS must be a power of two");
   end
   if (MIN_UNITS != (1 << MIN_LOG) || MIN_UNITS < 2) begin : g_bad_min
      $error("MIN_UNITS must be a power of two of at least 2");
   end
   if (ORDERS < 3) begin : g_bad_orders
      $error("region must hold at least three orders");
   end

   logic [OW-1:0]             need_order, q_order, set_order, clr_order;
   logic                      too_big, q_free, set_en, clr_en;
   logic [IW-1:0]             q_idx, set_idx, clr_idx;
   logic [ORDERS-1:0]         any_free;
   logic [ORDERS-1:0][IW-1:0] low_idx;
   logic [NBITS-1:0]          map_bits;

   buddy_order_calc #(.ORDERS(ORDERS), .MIN_LOG(MIN_LOG), .SW(SW), .OW(OW)) u_calc (
      .size_i       (alloc_size),
      .need_order_o (need_order),
      .too_big_o    (too_big)
   );

   buddy_free_map #(.ORDERS(ORDERS), .OW(OW), .IW(IW), .NBITS(NBITS)) u_map (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .set_order (set_order),
      .set_idx   (set_idx),
      .clr_en    (clr_en),
      .clr_order (clr_order),
      .clr_idx   (clr_idx),
      .q_order   (q_order),
      .q_idx     (q_idx),
      .q_free    (q_free),
      .any_free  (any_free),
      .low_idx   (low_idx),
      .bits_o    (map_bits)
   );

   buddy_ctrl #(.AW(AW), .MIN_LOG(MIN_LOG), .MIN_UNITS(MIN_UNITS), .ORDERS(ORDERS),
                .OW(OW), .IW(IW), .SW(SW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_req   (alloc_req),
      .alloc_size  (alloc_size),
      .free_req    (free_req),
      .free_base   (free_base),
      .free_order  (free_order),
      .need_order  (need_order),
      .too_big     (too_big),
      .any_free    (any_free),
      .low_idx     (low_idx),
      .q_free      (q_free),
      .q_order     (q_order),
      .q_idx       (q_idx),
      .set_en      (set_en),
      .set_order   (set_order),
      .set_idx     (set_idx),
      .clr_en      (clr_en),
      .clr_order   (clr_order),
      .clr_idx     (clr_idx),
      .alloc_done  (alloc_done),
      .alloc_fail  (alloc_fail),
      .alloc_base  (alloc_base),
      .alloc_order (alloc_order),
      .free_done   (free_done),
      .busy        (busy)
   );

   assert_fail_keeps_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_done && alloc_fail) |-> (map_bits == $past(map_bits)));
   assert_single_top_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
      map_bits[NBITS-1] |-> (map_bits[NBITS-2:0] == '0));
endmodule

// File: tb/buddy_allocator_bench.sv
module buddy_allocator_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int OW = 3;
   localparam int SW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          alloc_req = 1'b0;
   logic [SW-1:0] alloc_size = '0;
   logic          free_req = 1'b0;
   logic [AW-1:0] free_base = '0;
   logic [OW-1:0] free_order = '0;
   logic          alloc_done, alloc_fail, free_done, busy;
   logic [AW-1:0] alloc_base;
   logic [OW-1:0] alloc_order;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;

   buddy_allocator u_buddy_allocator (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_size(alloc_size),
      .free_req(free_req), .free_base(free_base), .free_order(free_order),
      .alloc_done(alloc_done), .alloc_fail(alloc_fail), .alloc_base(alloc_base),
      .alloc_order(alloc_order), .free_done(free_done), .busy(busy)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // issue one allocation and compare result and latency
   task automatic do_alloc(input int size, input bit exp_fail, input int exp_base,
                           input int exp_order, input int exp_lat, input string tag);
      int n;
      bit saw_free_done;
      @(negedge clk);
      alloc_req  = 1'b1;
      alloc_size = SW'(size);
      @(negedge clk);
      alloc_req = 1'b0;
      n = 1;
      saw_free_done = 1'b0;
      check(busy == 1'b1, {tag, " R10 busy after accept"}, busy, 1);
      while (!alloc_done && n < 40) begin
         @(negedge clk);
         n++;
         if (free_done) saw_free_done = 1'b1;
      end
      check(alloc_done == 1'b1, {tag, " done seen"}, alloc_done, 1);
      check(alloc_fail == exp_fail, {tag, " fail flag"}, alloc_fail, exp_fail);
      if (!exp_fail) begin
         check(int'(alloc_base) == exp_base, {tag, " base"}, alloc_base, exp_base);
         check(int'(alloc_order) == exp_order, {tag, " order"}, alloc_order, exp_order);
      end
      check(n == exp_lat, {tag, " R11 latency"}, n, exp_lat);
      check(!saw_free_done, {tag, " R10 no release pulse"}, saw_free_done, 0);
      @(negedge clk);
      check(alloc_done == 1'b0, {tag, " R10 done is one pulse"}, alloc_done, 0);
   endtask

   task automatic do_free(input int base, input int order, input int exp_lat,
                          input string tag);
      int n;
      @(negedge clk);
      free_req   = 1'b1;
      free_base  = AW'(base);
      free_order = OW'(order);
      @(negedge clk);
      free_req = 1'b0;
      n = 1;
      while (!free_done && n < 40) begin
         @(negedge clk);
         n++;
      end
      check(free_done == 1'b1, {tag, " release done"}, free_done, 1);
      check(n == exp_lat, {tag, " merge count latency"}, n, exp_lat);
      @(negedge clk);
      check(free_done == 1'b0, {tag, " R10 release pulse width"}, free_done, 0);
   endtask

   task automatic t_reset();
      check(busy == 1'b0, "R1 busy at reset", busy, 0);
      check(alloc_done == 1'b0, "R1 alloc_done at reset", alloc_done, 0);
      check(free_done == 1'b0, "R1 free_done at reset", free_done, 0);
      do_alloc(1024, 0, 0, 4, 2, "R1 whole region");
      do_alloc(64, 1, 0, 0, 2, "R1 nothing smaller free");
      do_free(0, 4, 2, "R1 region back");
   endtask

   task automatic t_split_fill();
      do_alloc(1, 0, 0, 0, 6, "R5 R2 split to minimum");
      do_alloc(100, 0, 128, 1, 2, "R5 R2 upper half at order 1");
      do_alloc(0, 0, 64, 0, 2, "R2 zero size to order 0");
      do_alloc(129, 0, 256, 2, 2, "R2 R3 round 129 up");
      do_alloc(512, 0, 512, 3, 2, "R5 R3 upper half at order 3");
   endtask

   task automatic t_failures();
      do_alloc(1025, 1, 0, 0, 2, "R6 oversize");
      do_alloc(2047, 1, 0, 0, 2, "R6 largest size value");
      do_alloc(64, 1, 0, 0, 2, "R7 region full");
   endtask

   task automatic t_partial_merge();
      do_free(64, 0, 2, "R9 buddy 0 in use");
      do_alloc(64, 0, 64, 0, 2, "R9 R7 block stayed at order 0");
      do_free(64, 0, 2, "R9 release again");
      do_free(0, 0, 3, "R9 R8 one merge then stop");
      do_alloc(128, 0, 0, 1, 2, "R8 merged block at order 1");
      do_free(0, 1, 2, "R9 buddy 128 in use");
      do_free(128, 1, 3, "R8 R9 merge to order 2");
      do_free(512, 3, 2, "R9 order 3 buddy not whole");
   endtask

   task automatic t_smallest_order();
      do_alloc(200, 0, 0, 2, 2, "R4 smallest order first");
      do_free(0, 2, 2, "R9 buddy 256 in use");
      do_free(256, 2, 4, "R8 merge up to region");
      do_alloc(1024, 0, 0, 4, 2, "R8 region rebuilt");
      do_free(0, 4, 2, "R8 region back");
   endtask

   task automatic t_priority();
      int n;
      bit saw_free_done;
      @(negedge clk);
      alloc_req  = 1'b1;
      alloc_size = SW'(1024);
      free_req   = 1'b1;
      free_base  = '0;
      free_order = OW'(4);
      @(negedge clk);
      alloc_req = 1'b0;
      free_req  = 1'b0;
      n = 1;
      saw_free_done = 1'b0;
      while (!alloc_done && n < 40) begin
         @(negedge clk);
         n++;
      end
      check(alloc_done && !alloc_fail, "R10 alloc wins", alloc_fail, 0);
      check(int'(alloc_order) == 4, "R10 alloc wins order", alloc_order, 4);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (free_done) saw_free_done = 1'b1;
      end
      check(!saw_free_done, "R10 release ignored", saw_free_done, 0);
      do_alloc(64, 1, 0, 0, 2, "R10 region still held");
      do_free(0, 4, 2, "R10 region back");
   endtask

   task automatic t_busy_ignore();
      int n;
      bit saw_free_done;
      @(negedge clk);
      alloc_req  = 1'b1;
      alloc_size = SW'(64);
      @(negedge clk);
      alloc_req  = 1'b0;
      free_req   = 1'b1;
      free_base  = '0;
      free_order = OW'(4);
      @(negedge clk);
      free_req = 1'b0;
      n = 2;
      saw_free_done = 1'b0;
      while (!alloc_done && n < 40) begin
         @(negedge clk);
         n++;
         if (free_done) saw_free_done = 1'b1;
      end
      check(int'(alloc_base) == 0 && int'(alloc_order) == 0, "R10 busy alloc result",
            alloc_base, 0);
      check(n == 6, "R11 four halvings", n, 6);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (free_done) saw_free_done = 1'b1;
      end
      check(!saw_free_done, "R10 release while busy ignored", saw_free_done, 0);
      do_alloc(512, 0, 512, 3, 2, "R10 upper half still free");
      do_free(512, 3, 2, "R10 back");
      do_free(0, 0, 6, "R8 R11 four merges");
      do_alloc(1024, 0, 0, 4, 2, "R8 full region after chain");
      do_free(0, 4, 2, "R8 final release");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_split_fill();
      t_failures();
      t_partial_merge();
      t_smallest_order();
      t_priority();
      t_busy_ignore();
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule